// File: doc/BRIEF.md
# Receive Character Holding and Error Status

This block sits behind the shift stage of an asynchronous serial receiver. It stores each completed character and reports the receiver's condition to a host bus. For every finished character the shift stage gives a one-cycle strobe, the character bits, a noise indication and the sampled value of the stop bit. The block holds the character in a data register and raises a full flag. It also maintains three sticky error flags: overrun, noise and framing error.

The host clears the flags by reading in two steps. A status read takes a snapshot of which flags are set. A later data read hands over the held character, empties the holding register, and clears only the flags that the snapshot saw set. If a character arrives while the previous one is still unread, that new character is lost and the held character stays as it was. Two interrupt request outputs are formed from the flags and three enable inputs. The error request combines overrun and framing error. The noise request stands alone.

Top module: `rx_status_core`

## Requirements
- R1: After reset the full flag, all three error flags, both interrupt requests and the data register are 0, whatever the enable inputs are.
- R2: A character strobe that arrives while the full flag is 0 loads the character into the data register and sets the full flag on the next clock edge.
- R3: A data-read strobe returns the held character on `rx_data_o` and clears the full flag. A character strobe in the same cycle is judged against the full flag's value before that read.
- R4: A character strobe that arrives while the full flag is 1 sets the overrun flag, drops the new character, and leaves the data register unchanged.
- R5: An error flag clears on a data read only when the last status read before that data read saw the flag at 1.
- R6: A data read that follows no status read, or follows a status read that saw the flag at 0, leaves the flag set.
- R7: A loaded character that carries the noise indication sets the noise flag. The R5 sequence clears it.
- R8: A loaded character whose sampled stop bit is 0 sets the framing flag. The R5 sequence clears it.
- R9: A character dropped by an overrun changes neither the noise flag nor the framing flag, whatever its indications are.
- R10: When an event that sets a flag occurs in the same cycle as a data read that would clear that flag, the flag stays set.
- R11: `err_irq_o` is 1 exactly when the overrun flag and its enable are both 1, or the framing flag and its enable are both 1.
- R12: `nf_irq_o` is 1 exactly when the noise flag and its enable are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| char_vld_i | input | 1 | One-cycle strobe: a character has completed |
| char_dat_i | input | DATA_W | Bits of the completed character |
| char_noise_i | input | 1 | Noise was seen while this character was sampled |
| char_stop_i | input | 1 | Sampled stop-bit value (0 means a framing error) |
| rd_stat_i | input | 1 | Bus status-register read strobe |
| rd_data_i | input | 1 | Bus data-register read strobe |
| ovr_ie_i | input | 1 | Overrun interrupt enable |
| fe_ie_i | input | 1 | Framing-error interrupt enable |
| nf_ie_i | input | 1 | Noise interrupt enable |
| rx_data_o | output | DATA_W | Held character |
| rx_full_o | output | 1 | Data register holds an unread character |
| ovr_flag_o | output | 1 | Overrun flag |
| nf_flag_o | output | 1 | Noise flag |
| fe_flag_o | output | 1 | Framing-error flag |
| err_irq_o | output | 1 | Error interrupt request (overrun or framing) |
| nf_irq_o | output | 1 | Noise interrupt request |

## Verification
The bench builds the block with `DATA_W = 9` and `SYNC_STAGES = 3`. The 9-bit width puts the top character bit through the holding register and out on the read path, so a path sized to 8 bits would be caught. The three-stage synchronizer moves the end of reset one cycle later than the default does. The directed scenarios cover the timing corners of the flag logic: a data read that follows no status read, a status read that misses an overrun, and a character strobe that arrives in the same cycle as a data read.

// File: rtl/rxstat_pkg.sv
package rxstat_pkg;
  localparam int NUM_ERR = 3;
  localparam int ERR_OVR = 0;
  localparam int ERR_NF  = 1;
  localparam int ERR_FE  = 2;
  typedef logic [NUM_ERR-1:0] err_vec_t;
endpackage

// File: rtl/rx_rst_sync.sv
module rx_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_i,
  output logic rst_n_o
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] sync_q;
  logic [TOP:0] sync_d;

  always_comb begin
    sync_d = {sync_q[TOP-1:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) sync_q <= '0;
    else          sync_q <= sync_d;
  end

  assign rst_n_o = sync_q[TOP];

  initial begin
    AST_SYNC_DEPTH: assert (STAGES >= 2); // R1
  end
endmodule

// File: rtl/rx_hold_reg.sv
module rx_hold_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_vld_i,
  input  logic [DATA_W-1:0] char_dat_i,
  input  logic              rd_data_i,
  output logic              load_o,
  output logic              ovr_evt_o,
  output logic              full_o,
  output logic [DATA_W-1:0] data_o
);
  logic              full_q, full_d;
  logic [DATA_W-1:0] data_q, data_d;
  logic              data_en;

  always_comb begin
    load_o    = char_vld_i & ~full_q;
    ovr_evt_o = char_vld_i &  full_q;
    data_en   = load_o;
    data_d    = char_dat_i;
    full_d    = full_q;
    if (load_o)         full_d = 1'b1;
    else if (rd_data_i) full_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      data_q <= '0;
    end else begin
      full_q <= full_d;
      if (data_en) data_q <= data_d;
    end
  end

  assign full_o = full_q;
  assign data_o = data_q;

  AST_LOAD_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    (char_vld_i && !full_o) |=> (full_o && data_o == $past(char_dat_i))); // R2
  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_i && !char_vld_i) |=> !full_o); // R3
  AST_OVR_KEEPS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    (char_vld_i && full_o) |=> $stable(data_o)); // R4
endmodule

// File: rtl/rx_err_flag.sv
module rx_err_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic rd_stat_i,
  input  logic rd_data_i,
  output logic flag_o
);
  logic flag_q, flag_d;
  logic armed_q, armed_d;
  logic clr;

  always_comb begin
    clr    = rd_data_i & armed_q;
    flag_d = flag_q;
    if (set_i)    flag_d = 1'b1;
    else if (clr) flag_d = 1'b0;
    armed_d = armed_q;
    if (rd_stat_i)      armed_d = flag_q;
    else if (rd_data_i) armed_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q  <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      flag_q  <= flag_d;
      armed_q <= armed_d;
    end
  end

  assign flag_o = flag_q;

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> flag_o); // R10
  AST_FALL_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(flag_o) |-> $past(rd_data_i)); // R5
  AST_UNARMED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data_i && !armed_q && flag_o) |=> flag_o); // R6
endmodule

// File: rtl/rx_status_core.sv
module rx_status_core
  import rxstat_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_vld_i,
  input  logic [DATA_W-1:0] char_dat_i,
  input  logic              char_noise_i,
  input  logic              char_stop_i,
  input  logic              rd_stat_i,
  input  logic              rd_data_i,
  input  logic              ovr_ie_i,
  input  logic              fe_ie_i,
  input  logic              nf_ie_i,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              rx_full_o,
  output logic              ovr_flag_o,
  output logic              nf_flag_o,
  output logic              fe_flag_o,
  output logic              err_irq_o,
  output logic              nf_irq_o
);
  logic     rst_n_s;
  logic     load;
  logic     ovr_evt;
  err_vec_t err_set;
  err_vec_t err_q;

  rx_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk     (clk),
    .rst_n_i (rst_n),
    .rst_n_o (rst_n_s)
  );

  rx_hold_reg #(.DATA_W(DATA_W)) u_hold (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .char_vld_i (char_vld_i),
    .char_dat_i (char_dat_i),
    .rd_data_i  (rd_data_i),
    .load_o     (load),
    .ovr_evt_o  (ovr_evt),
    .full_o     (rx_full_o),
    .data_o     (rx_data_o)
  );

  always_comb begin
    err_set          = '0;
    err_set[ERR_OVR] = ovr_evt;
    err_set[ERR_NF]  = load & char_noise_i;
    err_set[ERR_FE]  = load & ~char_stop_i;
  end

  for (genvar g = 0; g < NUM_ERR; g++) begin : g_flag
    rx_err_flag u_flag (
      .clk       (clk),
      .rst_n     (rst_n_s),
      .set_i     (err_set[g]),
      .rd_stat_i (rd_stat_i),
      .rd_data_i (rd_data_i),
      .flag_o    (err_q[g])
    );
  end

  assign ovr_flag_o = err_q[ERR_OVR];
  assign nf_flag_o  = err_q[ERR_NF];
  assign fe_flag_o  = err_q[ERR_FE];
  assign err_irq_o  = (err_q[ERR_OVR] & ovr_ie_i) | (err_q[ERR_FE] & fe_ie_i);
  assign nf_irq_o   = err_q[ERR_NF] & nf_ie_i;

  AST_DROP_NO_NOISE: assert property (@(posedge clk) disable iff (!rst_n_s)
    (char_vld_i && rx_full_o && !nf_flag_o) |=> !nf_flag_o); // R9
  AST_DROP_NO_FRAME: assert property (@(posedge clk) disable iff (!rst_n_s)
    (char_vld_i && rx_full_o && !fe_flag_o) |=> !fe_flag_o); // R9
  AST_OVR_ONLY_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n_s)
    $rose(ovr_flag_o) |-> $past(rx_full_o && char_vld_i)); // R4
  AST_ERR_IRQ_QUIET: assert property (@(posedge clk) disable iff (!rst_n_s)
    (!ovr_flag_o && !fe_flag_o) |-> !err_irq_o); // R11
endmodule

// File: tb/rx_status_core_tb.sv
module rx_status_core_tb;
  localparam int DW = 9;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          char_vld, char_noise, char_stop, rd_stat, rd_data;
  logic          ovr_ie, fe_ie, nf_ie;
  logic [DW-1:0] char_dat;
  logic [DW-1:0] rx_data;
  logic          rx_full, ovr_f, nf_f, fe_f, err_irq, nf_irq;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  rx_status_core #(.DATA_W(DW), .SYNC_STAGES(3)) u_dut (
    .clk(clk), .rst_n(rst_n),
    .char_vld_i(char_vld), .char_dat_i(char_dat),
    .char_noise_i(char_noise), .char_stop_i(char_stop),
    .rd_stat_i(rd_stat), .rd_data_i(rd_data),
    .ovr_ie_i(ovr_ie), .fe_ie_i(fe_ie), .nf_ie_i(nf_ie),
    .rx_data_o(rx_data), .rx_full_o(rx_full),
    .ovr_flag_o(ovr_f), .nf_flag_o(nf_f), .fe_flag_o(fe_f),
    .err_irq_o(err_irq), .nf_irq_o(nf_irq)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  // all helpers start and end at a falling edge
  task automatic send(input int d, input bit nz, input bit stp);
    char_vld = 1'b1; char_dat = DW'(d); char_noise = nz; char_stop = stp;
    @(negedge clk);
    char_vld = 1'b0; char_noise = 1'b0; char_stop = 1'b1;
  endtask

  task automatic do_stat();
    rd_stat = 1'b1;
    @(negedge clk);
    rd_stat = 1'b0;
  endtask

  task automatic do_data(output int got);
    got = int'(rx_data);
    rd_data = 1'b1;
    @(negedge clk);
    rd_data = 1'b0;
  endtask

  task automatic clear_all();
    int g;
    do_stat();
    do_data(g);
  endtask

  task automatic t_reset();
    ovr_ie = 1'b1; fe_ie = 1'b1; nf_ie = 1'b1;
    chk("R1 full", int'(rx_full), 0);
    chk("R1 flags", int'({ovr_f, nf_f, fe_f}), 0);
    chk("R1 irqs", int'({err_irq, nf_irq}), 0);
    chk("R1 data", int'(rx_data), 0);
    ovr_ie = 1'b0; fe_ie = 1'b0; nf_ie = 1'b0;
  endtask

  task automatic t_load_read();
    int g;
    send(9'h1A5, 1'b0, 1'b1);
    chk("R2 full", int'(rx_full), 1);
    chk("R2 data", int'(rx_data), 'h1A5);
    do_data(g);
    chk("R3 read value", g, 'h1A5);
    chk("R3 full cleared", int'(rx_full), 0);
    send(9'h05A, 1'b0, 1'b1);
    chk("R2 second load", int'(rx_data), 'h05A);
    do_data(g);
  endtask

  task automatic t_overrun();
    int g;
    ovr_ie = 1'b1;
    send(9'h011, 1'b0, 1'b1);
    send(9'h122, 1'b0, 1'b1);
    chk("R4 ovr set", int'(ovr_f), 1);
    chk("R4 data kept", int'(rx_data), 'h011);
    chk("R11 err_irq from ovr", int'(err_irq), 1);
    do_data(g);
    chk("R6 no status read", int'(ovr_f), 1);
    chk("R3 full cleared", int'(rx_full), 0);
    do_stat();
    do_data(g);
    chk("R5 ovr cleared", int'(ovr_f), 0);
    chk("R11 err_irq low", int'(err_irq), 0);
    ovr_ie = 1'b0;
  endtask

  task automatic t_delayed();
    int g;
    send(9'h0A1, 1'b0, 1'b1);
    do_stat();
    send(9'h0B2, 1'b0, 1'b1);
    chk("R4 ovr after stat", int'(ovr_f), 1);
    do_data(g);
    chk("R3 returns first", g, 'h0A1);
    chk("R6 stale snapshot", int'(ovr_f), 1);
    send(9'h0C3, 1'b0, 1'b1);
    do_stat();
    do_data(g);
    chk("R2 third loaded", g, 'h0C3);
    chk("R5 ovr cleared", int'(ovr_f), 0);
  endtask

  task automatic t_noise();
    send(9'h033, 1'b1, 1'b1);
    chk("R7 nf set", int'(nf_f), 1);
    chk("R7 fe clear", int'(fe_f), 0);
    nf_ie = 1'b1;
    #1 chk("R12 nf_irq on", int'(nf_irq), 1);
    nf_ie = 1'b0;
    #1 chk("R12 nf_irq off", int'(nf_irq), 0);
    @(negedge clk);
    clear_all();
    chk("R7 nf cleared", int'(nf_f), 0);
  endtask

  task automatic t_framing();
    send(9'h144, 1'b0, 1'b0);
    chk("R8 fe set", int'(fe_f), 1);
    ovr_ie = 1'b1;
    #1 chk("R11 ovr_ie only", int'(err_irq), 0);
    ovr_ie = 1'b0; fe_ie = 1'b1;
    #1 chk("R11 fe_ie", int'(err_irq), 1);
    fe_ie = 1'b0;
    @(negedge clk);
    clear_all();
    chk("R8 fe cleared", int'(fe_f), 0);
  endtask

  task automatic t_drop();
    send(9'h055, 1'b0, 1'b1);
    send(9'h066, 1'b1, 1'b0);
    chk("R9 ovr", int'(ovr_f), 1);
    chk("R9 nf untouched", int'(nf_f), 0);
    chk("R9 fe untouched", int'(fe_f), 0);
    chk("R9 data kept", int'(rx_data), 'h055);
    clear_all();
    chk("R5 cleared", int'(ovr_f), 0);
  endtask

  task automatic t_set_wins();
    int g;
    send(9'h077, 1'b0, 1'b1);
    send(9'h088, 1'b0, 1'b1);
    do_stat();
    rd_data = 1'b1; char_vld = 1'b1; char_dat = 9'h199; char_noise = 1'b1;
    @(negedge clk);
    rd_data = 1'b0; char_vld = 1'b0; char_noise = 1'b0;
    chk("R10 ovr kept", int'(ovr_f), 1);
    chk("R3 full judged pre-read", int'(rx_full), 0);
    chk("R9 no noise from drop", int'(nf_f), 0);
    chk("R10 data kept", int'(rx_data), 'h077);
    do_stat();
    do_data(g);
    chk("R5 cleared after", int'(ovr_f), 0);
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    char_vld = 1'b0; char_dat = '0; char_noise = 1'b0; char_stop = 1'b1;
    rd_stat = 1'b0; rd_data = 1'b0;
    ovr_ie = 1'b0; fe_ie = 1'b0; nf_ie = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_load_read();
    t_overrun();
    t_delayed();
    t_noise();
    t_framing();
    t_drop();
    t_set_wins();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule